// File: doc/BRIEF.md
# Boot-Time Configuration Loader over a Two-Wire Bus

This block runs once after reset. It fills an internal 8-bit register file from an external two-wire serial EEPROM, then gives the bus up to a slave port. A strap input decides whether the load happens at all. When the strap is high, the block becomes bus master. It sets the EEPROM word pointer to zero and reads one count byte. It then reads that many further bytes. The bytes form address/data records, and each complete record becomes one register write.

When the strap is low, the block goes straight to slave mode and leaves the bus untouched. If any addressing byte is not acknowledged, the block sends a STOP and also goes to slave mode. The busy flag holds the host off until the hand-over. The configuration image is expected to place the vendor and product ID registers first, so they are valid before enumeration.

Top module: `eeboot_loader`

## Requirements
- R1: The strap is sampled once, on the first clock edge after reset release. With the strap high the load runs. With it low, the block enters slave mode without issuing any START, and later strap changes have no effect.
- R2: The load begins with START, byte 0xA0 (device 0x50, write), word address 0x00, repeated START, and byte 0xA1 (device 0x50, read).
- R3: The first byte read is a count N, and exactly N further bytes are then read.
- R4: The data bytes are taken in pairs, register address first and then data. Each pair produces one single-cycle reg_we_o pulse. An unpaired final byte produces no write.
- R5: The master ACKs every byte it reads except the last, NACKs the last, and then issues exactly one STOP.
- R6: A NACK on 0xA0, on the word address or on 0xA1 ends the load at once: STOP, no register writes, no data bytes read, and slave mode.
- R7: busy_o is high in reset and stays high until slave hand-over, then falls for good. In slave mode both bus lines are released and slave_addr_o reads 0x20. Reset state: busy_o=1, slave_en_o=0, no line driven, no write.
- R8: SCL is the system clock divided by 4*Q, where Q = CLK_HZ/(4*SCL_HZ). Rising SCL edges within one byte are exactly 4*Q cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_i | input | 1 | Load-enable strap, sampled once after reset |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| reg_we_o | output | 1 | Register write strobe |
| reg_addr_o | output | 8 | Register write address |
| reg_data_o | output | 8 | Register write data |
| busy_o | output | 1 | Load in progress, host must wait |
| slave_en_o | output | 1 | Bus handed to the slave port |
| slave_addr_o | output | 7 | Address the slave port answers to |

## Verification
A wrong sequencer state shows up on the bus within one byte time. The result is a wrong address byte, a missing repeated START, or an ACK/NACK on the wrong byte, and the EEPROM responder records each of these. A wrong byte count or a broken pairing changes the number or content of the register writes, which are compared with records computed from the image. A stuck bit engine stops the hand-over, so busy_o never falls within the per-run cycle limit.

// File: rtl/eeboot_pkg.sv
package eeboot_pkg;
  typedef enum logic [1:0] {CMD_START, CMD_STOP, CMD_WRITE, CMD_READ} io_cmd_e;
  typedef enum logic [3:0] {
    S_BOOT, S_ST1, S_DEVW, S_WADR, S_RST, S_DEVR, S_CNT, S_DAT, S_STOP, S_SLAVE
  } seq_state_e;
endpackage

// File: rtl/eeboot_clkdiv.sv
module eeboot_clkdiv #(
  parameter int QDIV = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == CW'(QDIV - 1)) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/eeboot_byte_io.sv
// Bit engine: each bit spends four quarter phases; SDA changes only in phase 0 (SCL low)
// except inside START/STOP.
module eeboot_byte_io
  import eeboot_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       cmd_valid_i,
  input  io_cmd_e    cmd_i,
  input  logic [7:0] tx_i,
  input  logic       rd_last_i,
  input  logic       sda_i,
  output logic       done_o,
  output logic       ack_o,
  output logic [7:0] rx_o,
  output logic       scl_o,
  output logic       sda_o
);
  io_cmd_e    cmd_q;
  logic       active_q, ack_q, nack_q, done_q, scl_q, sda_q;
  logic [1:0] ph_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q;
  logic       ack_slot, last_bit, scl_n, sda_n, wbit;

  assign ack_slot = (bit_q == 4'd8);
  assign last_bit = (cmd_q == CMD_START || cmd_q == CMD_STOP) ? (bit_q == 4'd0) : ack_slot;

  always_comb begin
    if (cmd_q == CMD_WRITE) wbit = ack_slot ? 1'b1 : sh_q[7];
    else                    wbit = ack_slot ? ((ph_q == 2'd0) ? rd_last_i : nack_q) : 1'b1;
    case (cmd_q)
      CMD_START: begin scl_n = (ph_q == 2'd1 || ph_q == 2'd2); sda_n = (ph_q <= 2'd1); end
      CMD_STOP:  begin scl_n = (ph_q != 2'd0);                 sda_n = (ph_q >= 2'd2); end
      default:   begin scl_n = (ph_q == 2'd1 || ph_q == 2'd2); sda_n = wbit;           end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= CMD_STOP; active_q <= 1'b0; ack_q <= 1'b0; nack_q <= 1'b0;
      done_q <= 1'b0; scl_q <= 1'b1; sda_q <= 1'b1;
      ph_q <= '0; bit_q <= '0; sh_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (cmd_valid_i) begin
          active_q <= 1'b1;
          cmd_q    <= cmd_i;
          ph_q     <= '0;
          bit_q    <= '0;
          sh_q     <= (cmd_i == CMD_WRITE) ? tx_i : 8'h00;
        end
      end else if (tick_i) begin
        scl_q <= scl_n;
        sda_q <= sda_n;
        ph_q  <= ph_q + 1'b1;
        if (ph_q == 2'd0 && ack_slot) nack_q <= rd_last_i;
        if (ph_q == 2'd2) begin
          if (ack_slot)                ack_q <= !sda_i;
          else if (cmd_q == CMD_READ)  sh_q  <= {sh_q[6:0], sda_i};
        end
        if (ph_q == 2'd3) begin
          if (cmd_q == CMD_WRITE && !ack_slot) sh_q <= {sh_q[6:0], 1'b0};
          if (last_bit) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
      end
    end
  end

  assign done_o = done_q;
  assign ack_o  = ack_q;
  assign rx_o   = sh_q;
  assign scl_o  = scl_q;
  assign sda_o  = sda_q;
endmodule

// File: rtl/eeboot_seq.sv
module eeboot_seq
  import eeboot_pkg::*;
#(
  parameter logic [6:0] EE_ADDR = 7'h50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strap_i,
  input  logic       done_i,
  input  logic       ack_i,
  input  logic [7:0] rx_i,
  output logic       cmd_valid_o,
  output io_cmd_e    cmd_o,
  output logic [7:0] tx_o,
  output logic       rd_last_o,
  output logic       reg_we_o,
  output logic [7:0] reg_addr_o,
  output logic [7:0] reg_data_o,
  output logic       busy_o,
  output logic       slave_en_o
);
  seq_state_e st_q;
  logic       issued_q, odd_q, we_q, cmd_state;
  logic [7:0] rem_q, adr_q, waddr_q, wdata_q;

  always_comb begin
    cmd_state = 1'b1;
    cmd_o     = CMD_READ;
    tx_o      = 8'h00;
    case (st_q)
      S_ST1, S_RST: cmd_o = CMD_START;
      S_DEVW: begin cmd_o = CMD_WRITE; tx_o = {EE_ADDR, 1'b0}; end
      S_WADR: begin cmd_o = CMD_WRITE; tx_o = 8'h00; end
      S_DEVR: begin cmd_o = CMD_WRITE; tx_o = {EE_ADDR, 1'b1}; end
      S_CNT, S_DAT: cmd_o = CMD_READ;
      S_STOP: cmd_o = CMD_STOP;
      default: cmd_state = 1'b0;
    endcase
  end

  assign cmd_valid_o = cmd_state && !issued_q;
  // the count byte is its own last byte when it reads zero
  assign rd_last_o   = (st_q == S_CNT) ? (rx_i == 8'h00) : (rem_q == 8'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_BOOT; issued_q <= 1'b0; odd_q <= 1'b0; we_q <= 1'b0;
      rem_q <= '0; adr_q <= '0; waddr_q <= '0; wdata_q <= '0;
    end else begin
      we_q <= 1'b0;
      if (cmd_valid_o) issued_q <= 1'b1;
      if (st_q == S_BOOT) begin
        st_q <= strap_i ? S_ST1 : S_SLAVE;
      end else if (done_i) begin
        issued_q <= 1'b0;
        case (st_q)
          S_ST1:  st_q <= S_DEVW;
          S_DEVW: st_q <= ack_i ? S_WADR : S_STOP;
          S_WADR: st_q <= ack_i ? S_RST : S_STOP;
          S_RST:  st_q <= S_DEVR;
          S_DEVR: st_q <= ack_i ? S_CNT : S_STOP;
          S_CNT: begin
            rem_q <= rx_i;
            odd_q <= 1'b0;
            st_q  <= (rx_i == 8'h00) ? S_STOP : S_DAT;
          end
          S_DAT: begin
            rem_q <= rem_q - 1'b1;
            odd_q <= !odd_q;
            if (!odd_q) adr_q <= rx_i;
            else begin
              we_q    <= 1'b1;
              waddr_q <= adr_q;
              wdata_q <= rx_i;
            end
            if (rem_q == 8'd1) st_q <= S_STOP;
          end
          S_STOP: st_q <= S_SLAVE;
          default: st_q <= st_q;
        endcase
      end
    end
  end

  assign reg_we_o   = we_q;
  assign reg_addr_o = waddr_q;
  assign reg_data_o = wdata_q;
  assign busy_o     = (st_q != S_SLAVE);
  assign slave_en_o = (st_q == S_SLAVE);
endmodule

// File: rtl/eeboot_loader.sv
module eeboot_loader
  import eeboot_pkg::*;
#(
  parameter int         CLK_HZ     = 50_000_000,
  parameter int         SCL_HZ     = 100_000,
  parameter logic [6:0] EE_ADDR    = 7'h50,
  parameter logic [6:0] SLAVE_ADDR = 7'h20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strap_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic       reg_we_o,
  output logic [7:0] reg_addr_o,
  output logic [7:0] reg_data_o,
  output logic       busy_o,
  output logic       slave_en_o,
  output logic [6:0] slave_addr_o
);
  localparam int QRAW = CLK_HZ / (4 * SCL_HZ);
  localparam int QDIV = (QRAW > 0) ? QRAW : 1;

  logic       tick, cmd_valid, rd_last, done, ack, scl_lvl, sda_lvl;
  io_cmd_e    cmd;
  logic [7:0] tx, rx;

  eeboot_clkdiv #(.QDIV(QDIV)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  eeboot_byte_io u_io (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .cmd_valid_i(cmd_valid),
    .cmd_i(cmd), .tx_i(tx), .rd_last_i(rd_last), .sda_i(sda_i),
    .done_o(done), .ack_o(ack), .rx_o(rx), .scl_o(scl_lvl), .sda_o(sda_lvl)
  );

  eeboot_seq #(.EE_ADDR(EE_ADDR)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .strap_i(strap_i), .done_i(done),
    .ack_i(ack), .rx_i(rx), .cmd_valid_o(cmd_valid), .cmd_o(cmd), .tx_o(tx),
    .rd_last_o(rd_last), .reg_we_o(reg_we_o), .reg_addr_o(reg_addr_o),
    .reg_data_o(reg_data_o), .busy_o(busy_o), .slave_en_o(slave_en_o)
  );

  assign scl_oe_o     = !scl_lvl;
  assign sda_oe_o     = !sda_lvl;
  assign slave_addr_o = SLAVE_ADDR;
endmodule

// File: rtl/eeboot_loader_chk.sv
module eeboot_loader_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic slave_en_o,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic reg_we_o
);
  p_slave_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_en_o |=> slave_en_o);
  p_lines_free_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_en_o |-> (!scl_oe_o && !sda_oe_o));
  p_busy_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> slave_en_o);
  p_we_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);
  p_we_in_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (busy_o && !slave_en_o));
endmodule

bind eeboot_loader eeboot_loader_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .slave_en_o(slave_en_o),
  .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .reg_we_o(reg_we_o)
);

// File: tb/sim_eeboot_loader.sv
module sim_eeboot_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0;
  logic pull = 1'b0;
  logic scl_oe, sda_oe, we, busy, slv;
  logic [7:0] waddr, wdata;
  logic [6:0] saddr;
  wire  scl_w = !scl_oe;
  wire  sda_w = !(sda_oe || pull);

  always #10 clk = !clk;

  eeboot_loader #(.CLK_HZ(50_000_000), .SCL_HZ(5_000_000)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap), .sda_i(sda_w),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .reg_we_o(we), .reg_addr_o(waddr),
    .reg_data_o(wdata), .busy_o(busy), .slave_en_o(slv), .slave_addr_o(saddr)
  );

  localparam int QBIT = 8;  // 4 * Q with Q = 2

  int vectors = 0, fails = 0;
  logic [7:0] mem [0:255];
  int nak_sel = 0;
  // responder state
  logic prev_s = 1'b1, prev_d = 1'b1, mact = 1'b0, skip = 1'b0, rxm = 1'b1;
  logic ackit = 1'b0, macked = 1'b0, prev_busy = 1'b1;
  int bitc = 0, ph = 0, starts = 0, stops = 0, sent = 0, m_acks = 0, m_nacks = 0;
  int nrx = 0, nw = 0, busy_re = 0, bad_per = 0, cyc = 0, last_rise = 0;
  logic [7:0] rxb = 8'h00, ptr = 8'h00;
  logic [7:0] rxlog [0:7];
  logic [7:0] wa_log [0:15];
  logic [7:0] wd_log [0:15];

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic s, d;
    s = scl_w; d = sda_w;
    cyc++;
    if (!rst_n) begin
      prev_s = 1'b1; prev_d = 1'b1; mact = 1'b0; skip = 1'b0; rxm = 1'b1; pull = 1'b0;
      bitc = 0; ph = 0; starts = 0; stops = 0; sent = 0; m_acks = 0; m_nacks = 0;
      nrx = 0; nw = 0; busy_re = 0; bad_per = 0; last_rise = 0; prev_busy = 1'b1;
    end else begin
      if (we && nw < 16) begin wa_log[nw] = waddr; wd_log[nw] = wdata; end
      if (we) nw++;
      if (!prev_busy && busy) busy_re++;
      prev_busy = busy;
      if (prev_s && s && prev_d && !d) begin
        starts++; mact = 1'b1; skip = 1'b1; bitc = 0; rxm = 1'b1; ph = 0; rxb = 8'h00; pull = 1'b0;
      end else if (prev_s && s && !prev_d && d) begin
        stops++; mact = 1'b0; pull = 1'b0;
      end else if (mact && !prev_s && s) begin
        if (bitc >= 1 && (cyc - last_rise) != QBIT) bad_per++;
        last_rise = cyc;
        if (bitc < 8) begin
          if (rxm) rxb = {rxb[6:0], d};
        end else if (!rxm) begin
          macked = !d;
          if (!d) m_acks++; else m_nacks++;
        end
      end else if (mact && prev_s && !s) begin
        if (skip) skip = 1'b0;
        else if (bitc < 8) begin
          bitc++;
          if (bitc == 8) begin
            if (rxm) begin
              if (ph == 0)
                ackit = (rxb[7:1] == 7'h50) && !(nak_sel == 1 && !rxb[0]) && !(nak_sel == 3 && rxb[0]);
              else if (ph == 1) ackit = (nak_sel != 2);
              else ackit = 1'b1;
              pull = ackit;
            end else pull = 1'b0;
          end else if (!rxm) pull = !mem[ptr][7-bitc];
        end else begin
          bitc = 0;
          if (rxm) begin
            if (nrx < 8) rxlog[nrx] = rxb;
            nrx++;
            if (!ackit) mact = 1'b0;
            else if (ph == 0) begin
              if (rxb[0]) rxm = 1'b0; else ph = 1;
            end else if (ph == 1) begin
              ptr = rxb; ph = 2;
            end
          end else begin
            sent++;
            if (macked) ptr = ptr + 8'd1; else mact = 1'b0;
          end
          pull = (mact && !rxm) ? !mem[ptr][7] : 1'b0;
        end
      end
      prev_s = s; prev_d = d;
    end
  end

  task automatic run(input logic st, input int n, input int nak, input logic flip);
    int t;
    rst_n = 1'b0; strap = st; nak_sel = nak;
    mem[0] = 8'(n);
    for (int i = 1; i < 256; i++) mem[i] = 8'(i * 37 + n + 5);
    repeat (3) @(negedge clk);
    chk("R7 reset busy", int'(busy), 1);
    chk("R7 reset slave_en", int'(slv), 0);
    chk("R7 reset lines", int'(scl_oe) + int'(sda_oe) + int'(we), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    if (flip) strap = !st;
    t = 0;
    while (!slv && t < 5000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    chk("R7 hand-over", int'(slv), 1);
    chk("R7 busy low", int'(busy), 0);
    chk("R7 busy never re-rises", busy_re, 0);
    chk("R7 lines released", int'(scl_oe) + int'(sda_oe), 0);
    chk("R7 slave address", int'(saddr), 32);
    if (!st) begin
      chk("R1 no START when strap low", starts, 0);
      chk("R1 no writes when strap low", nw, 0);
    end else if (nak != 0) begin
      chk("R6 no writes", nw, 0);
      chk("R6 no data read", sent, 0);
      chk("R6 one STOP", stops, 1);
      chk("R6 starts", starts, (nak == 3) ? 2 : 1);
    end else begin
      chk("R2 starts", starts, 2);
      chk("R2 dev write byte", int'(rxlog[0]), 8'hA0);
      chk("R2 word address", int'(rxlog[1]), 0);
      chk("R2 dev read byte", int'(rxlog[2]), 8'hA1);
      chk("R3 bytes read", sent, n + 1);
      chk("R4 write count", nw, n / 2);
      for (int k = 0; k < n / 2 && k < 16; k++) begin
        chk("R4 write addr", int'(wa_log[k]), int'(mem[1 + 2 * k]));
        chk("R4 write data", int'(wd_log[k]), int'(mem[2 + 2 * k]));
      end
      chk("R5 acks", m_acks, n);
      chk("R5 nacks", m_nacks, 1);
      chk("R5 stops", stops, 1);
      chk("R8 scl period", bad_per, 0);
    end
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    run(1'b0, 4, 0, 1'b0);
    run(1'b0, 4, 0, 1'b1);  // R1: strap rises after sampling
    for (int n = 0; n < 12; n++) run(1'b1, n, 0, (n == 5));
    for (int k = 1; k < 4; k++) run(1'b1, 6, k, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule